// File: doc/BRIEF.md
# Windowed Indirect Register Access Port

This block is a small host-facing slave that opens a 16-bit internal address space through four byte-wide window locations. The host first places a target address into a pointer made of two byte registers, then reads or writes a data location. Each data access turns into a one-cycle request on a synchronous internal memory port, using the pointer as the address.

A mode location holds two control bits. The first sets which of the two pointer registers carries the upper byte. The second makes the pointer advance by one after every data access. With advance enabled, a run of consecutive locations needs only one address load.

Every host read, whether of a window register or of the data location, answers one cycle later with a one-cycle `host_rvalid` pulse.

Top module: `idx_win_port`

## Requirements
- R1: After reset the mode byte reads 0x00, the pointer is 0x0000, and `mem_req` and `host_rvalid` are low.
- R2: Window offset 0 is the mode byte, with pointer advance at bit 1 and byte-order select at bit 0. Offsets 1 and 2 are the pointer registers and offset 3 is the data location. Reads of mode bits 7..2 return 0.
- R3: With byte-order select at 0, offset 1 writes and reads pointer bits [15:8] and offset 2 writes and reads bits [7:0].
- R4: With byte-order select at 1, offset 1 maps to pointer bits [7:0] and offset 2 maps to bits [15:8].
- R5: A host write to offset 3 raises `mem_req` with `mem_we`=1 for that cycle only, with `mem_addr` equal to the pointer and `mem_wdata` equal to the host byte.
- R6: A host read of offset 3 raises `mem_req` with `mem_we`=0 for that cycle only, at the pointer address. On the next cycle `host_rdata` carries the byte the memory returned.
- R7: With pointer advance set, each data access adds 1 to the pointer after the access.
- R8: Advancing from 0xFFFF wraps the pointer to 0x0000.
- R9: With pointer advance clear, data accesses leave the pointer unchanged.
- R10: Reads of offsets 1 and 2 return the current pointer bytes under the active byte order, including values produced by advancing.
- R11: Every host read gives `host_rvalid`=1 with its data on the following cycle. A host write gives no `host_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 2 | Window offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read answer strobe |
| mem_req | output | 1 | Internal request strobe |
| mem_we | output | 1 | Internal request is a write |
| mem_addr | output | 16 | Internal address |
| mem_wdata | output | 8 | Internal write byte |
| mem_rdata | input | 8 | Internal read byte, one cycle after a read request |

## Verification
The bench loads the pointer under both byte orders and reads the pointer back. A design with the swap inverted or applied on one side only returns the wrong byte. It walks data accesses with pointer advance on and off. A design that advances before the access, or advances when advance is off, shows up as a wrong `mem_addr`. It drives the pointer across 0xFFFF. A design without a proper wrap gives a non-zero pointer there. Read answers are sampled on the cycle after the request, so a latency of zero or two cycles returns stale data.

// File: rtl/idx_win_pkg.sv
`timescale 1ns/1ps
package idx_win_pkg;
    localparam int unsigned OFS_W = 2;
    localparam logic [OFS_W-1:0] OFS_MODE = 2'd0;
    localparam logic [OFS_W-1:0] OFS_PA   = 2'd1;
    localparam logic [OFS_W-1:0] OFS_PB   = 2'd2;
    localparam logic [OFS_W-1:0] OFS_DATA = 2'd3;
    localparam int unsigned MODE_ADV_BIT = 1;
    localparam int unsigned MODE_SWAP_BIT = 0;

    typedef struct packed {
        logic wr_mode;
        logic wr_pa;
        logic wr_pb;
        logic data_wr;
        logic data_rd;
        logic any_rd;
    } win_dec_t;
endpackage

// File: rtl/idx_win_decode.sv
`timescale 1ns/1ps
module idx_win_decode
    import idx_win_pkg::*;
(
    input  logic             host_sel,
    input  logic             host_wr,
    input  logic [OFS_W-1:0] host_ofs,
    output win_dec_t         dec
);
    always_comb begin
        dec         = '0;
        dec.any_rd  = host_sel && !host_wr;
        dec.wr_mode = host_sel && host_wr && (host_ofs == OFS_MODE);
        dec.wr_pa   = host_sel && host_wr && (host_ofs == OFS_PA);
        dec.wr_pb   = host_sel && host_wr && (host_ofs == OFS_PB);
        dec.data_wr = host_sel && host_wr && (host_ofs == OFS_DATA);
        dec.data_rd = host_sel && !host_wr && (host_ofs == OFS_DATA);
    end
endmodule

// File: rtl/idx_win_ptr.sv
`timescale 1ns/1ps
module idx_win_ptr
    import idx_win_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_mode,
    input  logic                wr_pa,
    input  logic                wr_pb,
    input  logic                data_acc,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*DATA_W-1:0] ptr,
    output logic                adv,
    output logic                swap,
    output logic [DATA_W-1:0]   pa_byte,
    output logic [DATA_W-1:0]   pb_byte
);
    localparam int unsigned PTR_W = 2 * DATA_W;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             adv;
        logic             swap;
    } ptr_state_t;

    ptr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_mode) begin
            s_d.adv  = wdata[MODE_ADV_BIT];
            s_d.swap = wdata[MODE_SWAP_BIT];
        end
        if (wr_pa) begin
            if (s_q.swap) s_d.ptr[DATA_W-1:0]     = wdata;
            else          s_d.ptr[PTR_W-1:DATA_W] = wdata;
        end
        if (wr_pb) begin
            if (s_q.swap) s_d.ptr[PTR_W-1:DATA_W] = wdata;
            else          s_d.ptr[DATA_W-1:0]     = wdata;
        end
        if (data_acc && s_q.adv) begin
            s_d.ptr = s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ptr     = s_q.ptr;
    assign adv     = s_q.adv;
    assign swap    = s_q.swap;
    assign pa_byte = s_q.swap ? s_q.ptr[DATA_W-1:0] : s_q.ptr[PTR_W-1:DATA_W];
    assign pb_byte = s_q.swap ? s_q.ptr[PTR_W-1:DATA_W] : s_q.ptr[DATA_W-1:0];

    p_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && adv |=> ptr == $past(ptr) + 1'b1);
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && adv && (ptr == '1) |=> ptr == '0);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && !adv |=> $stable(ptr));
endmodule

// File: rtl/idx_win_port.sv
`timescale 1ns/1ps
module idx_win_port
    import idx_win_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_sel,
    input  logic                host_wr,
    input  logic [1:0]          host_ofs,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                host_rvalid,
    output logic                mem_req,
    output logic                mem_we,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata
);
    localparam int unsigned PTR_W = 2 * DATA_W;

    typedef struct packed {
        logic              valid;
        logic              from_mem;
        logic [DATA_W-1:0] byte_v;
    } rd_state_t;

    win_dec_t          dec;
    logic [PTR_W-1:0]  ptr;
    logic              adv, swap;
    logic [DATA_W-1:0] pa_byte, pb_byte;
    rd_state_t         r_d, r_q;

    idx_win_decode u_dec (
        .host_sel (host_sel),
        .host_wr  (host_wr),
        .host_ofs (host_ofs),
        .dec      (dec)
    );

    idx_win_ptr #(.DATA_W(DATA_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_mode  (dec.wr_mode),
        .wr_pa    (dec.wr_pa),
        .wr_pb    (dec.wr_pb),
        .data_acc (dec.data_wr || dec.data_rd),
        .wdata    (host_wdata),
        .ptr      (ptr),
        .adv      (adv),
        .swap     (swap),
        .pa_byte  (pa_byte),
        .pb_byte  (pb_byte)
    );

    always_comb begin
        r_d          = '0;
        r_d.valid    = dec.any_rd;
        r_d.from_mem = dec.data_rd;
        case (host_ofs)
            OFS_MODE: begin
                r_d.byte_v[MODE_ADV_BIT]  = adv;
                r_d.byte_v[MODE_SWAP_BIT] = swap;
            end
            OFS_PA:  r_d.byte_v = pa_byte;
            OFS_PB:  r_d.byte_v = pb_byte;
            default: r_d.byte_v = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_req     = dec.data_wr || dec.data_rd;
    assign mem_we      = dec.data_wr;
    assign mem_addr    = ptr;
    assign mem_wdata   = host_wdata;
    assign host_rvalid = r_q.valid;
    assign host_rdata  = r_q.from_mem ? mem_rdata : r_q.byte_v;

    p_read_answer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel && !host_wr |=> host_rvalid);
    p_no_answer_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel && host_wr |=> !host_rvalid);
    p_mem_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |=> host_rvalid && (host_rdata == mem_rdata));
    p_write_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> host_sel && host_wr && (host_ofs == OFS_DATA));
endmodule

// File: tb/idx_win_port_tb.sv
`timescale 1ns/1ps
module idx_win_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_wr = 1'b0;
    logic [1:0]  host_ofs = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    logic        m_adv = 1'b0, m_swap = 1'b0;
    logic [15:0] m_ptr = '0;

    always #4 clk = ~clk;

    idx_win_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return a[15:8] ^ {a[6:0], a[7]} ^ 8'hC3;
    endfunction

    always @(posedge clk) if (mem_req && !mem_we) mem_rdata <= mem_fn(mem_addr);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {rd, ofs[1:0], data[7:0]}
    localparam int NV = 17;
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 2'd0, 8'h00}, {1'b0, 2'd1, 8'h12}, {1'b0, 2'd2, 8'h34},
        {1'b1, 2'd1, 8'h00}, {1'b1, 2'd2, 8'h00}, {1'b0, 2'd3, 8'hAA},
        {1'b1, 2'd3, 8'h00}, {1'b1, 2'd0, 8'h00}, {1'b0, 2'd0, 8'h01},
        {1'b1, 2'd1, 8'h00}, {1'b1, 2'd2, 8'h00}, {1'b0, 2'd1, 8'h78},
        {1'b1, 2'd3, 8'h00}, {1'b0, 2'd0, 8'hFF}, {1'b1, 2'd0, 8'h00},
        {1'b0, 2'd3, 8'h55}, {1'b1, 2'd1, 8'h00}
    };

    function automatic string tag_of(input logic rd, input logic [1:0] ofs);
        if (ofs == 2'd0) return "R2";
        if (ofs == 2'd3) return rd ? "R6" : "R5";
        return m_swap ? "R4" : "R3";
    endfunction

    task automatic do_op(input logic rd, input logic [1:0] ofs, input logic [7:0] d, input string tag);
        logic [7:0] exp_rd;
        @(negedge clk);
        host_sel = 1'b1; host_wr = !rd; host_ofs = ofs; host_wdata = d;
        #1;
        check({tag, " mem_req"}, {31'd0, mem_req}, {31'd0, ofs == 2'd3});
        if (ofs == 2'd3) begin
            check({tag, " mem_we"}, {31'd0, mem_we}, {31'd0, !rd});
            check({tag, " mem_addr"}, {16'd0, mem_addr}, {16'd0, m_ptr});
            if (!rd) check({tag, " mem_wdata"}, {24'd0, mem_wdata}, {24'd0, d});
        end
        case (ofs)
            2'd0: exp_rd = {6'd0, m_adv, m_swap};
            2'd1: exp_rd = m_swap ? m_ptr[7:0] : m_ptr[15:8];
            2'd2: exp_rd = m_swap ? m_ptr[15:8] : m_ptr[7:0];
            default: exp_rd = mem_fn(m_ptr);
        endcase
        if (!rd) begin
            case (ofs)
                2'd0: begin m_adv = d[1]; m_swap = d[0]; end
                2'd1: if (m_swap) m_ptr[7:0] = d; else m_ptr[15:8] = d;
                2'd2: if (m_swap) m_ptr[15:8] = d; else m_ptr[7:0] = d;
                default: ;
            endcase
        end
        if (ofs == 2'd3 && m_adv) m_ptr = m_ptr + 16'd1;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
        check("R11 rvalid", {31'd0, host_rvalid}, {31'd0, rd});
        if (rd) check({tag, " rdata"}, {24'd0, host_rdata}, {24'd0, exp_rd});
        #1;
        check("R5/R6 single-cycle request", {31'd0, mem_req}, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        check("R1 rvalid", {31'd0, host_rvalid}, 32'd0);
        check("R1 ptr", {16'd0, mem_addr}, 32'd0);
        rst_n = 1'b1;
        do_op(1'b1, 2'd0, 8'h00, "R1 mode");
        do_op(1'b1, 2'd2, 8'h00, "R1 ptr");

        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][10], VEC[i][9:8], VEC[i][7:0], tag_of(VEC[i][10], VEC[i][9:8]));
        end

        // R7/R10: advancing pointer read back through both registers
        do_op(1'b1, 2'd3, 8'h00, "R7");
        do_op(1'b1, 2'd1, 8'h00, "R10");
        do_op(1'b1, 2'd2, 8'h00, "R10");
        // R8: wrap at 0xFFFF with byte-order 0
        do_op(1'b0, 2'd0, 8'h02, "R2");
        do_op(1'b0, 2'd1, 8'hFF, "R8");
        do_op(1'b0, 2'd2, 8'hFF, "R8");
        do_op(1'b0, 2'd3, 8'h9C, "R8");
        do_op(1'b1, 2'd1, 8'h00, "R8");
        do_op(1'b1, 2'd2, 8'h00, "R8");
        do_op(1'b1, 2'd3, 8'h00, "R8");
        // R9: advance clear holds the pointer
        do_op(1'b0, 2'd0, 8'h00, "R9");
        do_op(1'b0, 2'd1, 8'hAB, "R9");
        do_op(1'b0, 2'd3, 8'h11, "R9");
        do_op(1'b1, 2'd3, 8'h00, "R9");
        do_op(1'b1, 2'd1, 8'h00, "R9");
        do_op(1'b1, 2'd2, 8'h00, "R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule